// File: doc/BRIEF.md
# Management Data Serial Master

This block is a bus master for the two-wire station management interface found between Ethernet MACs and PHYs. It generates the management clock from the system clock and drives, or releases, the bidirectional data line. One transaction runs per accepted request. The host gives a raw 16-bit control word and, for a write, a 16-bit data word. The control word goes out bit for bit, so standard frames and vendor variants both pass through unchanged. Vendor variants include other opcodes and address bits given a new meaning.

Each transaction has four phases: a run of ones as a preamble, the header taken from the top fourteen control bits, two turnaround bit times, and sixteen data bits. On a write the master drives the two lowest control bits in the turnaround slot, then the write data. On a read the master releases the line from the turnaround onward and captures sixteen bits on rising clock edges.

The controller is a five-state machine:
- IDLE goes to PREAMBLE on an accepted request.
- PREAMBLE goes to HEADER after its last bit.
- HEADER goes to TURN after fourteen bits.
- TURN goes to DATA after two bits.
- DATA goes back to IDLE after sixteen bits, and that step raises the completion pulse.

Each step happens on a falling-edge strobe of the management clock.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, done, mdc and mdio_oe are 0 and rd_data is 0.
- R2: A request is accepted only in a cycle where busy is 0, and busy is 1 in the next cycle. A request raised while busy is 1 is ignored: it starts no frame and does not alter the frame in progress.
- R3: Every frame starts with 32 bits of value 1, driven with mdio_oe at 1.
- R4: Bits 15 down to 2 of the control word are driven MSB first, exactly as given. This includes nonstandard values such as opcode 00.
- R5: On a write, control bits 1 then 0 are driven in the two turnaround bit times (10 in a standard frame). The 16 write data bits follow, MSB first, with mdio_oe at 1 throughout.
- R6: On a read, mdio_oe is 0 from the first turnaround bit to the end of the frame. The 16 bits present on mdio_i at the mdc rising edges of the data phase are stored MSB first in rd_data.
- R7: mdc idles low. While busy, mdc toggles every HALF_DIV system clocks. A frame is 64 mdc periods, so done appears 128*HALF_DIV cycles after the accepting edge.
- R8: While the line is driven, mdio_o changes only at the clock edge where mdc falls. It is stable while mdc is high.
- R9: done is a one-cycle pulse in the first cycle where busy is 0 again. rd_data holds from that pulse until the next request is accepted, and is cleared to 0 when that request is accepted.
- R10: A request raised in the cycle done is 1 is accepted at the next edge, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request, taken when not busy |
| req_write | input | 1 | 1 selects write, 0 selects read |
| req_ctrl | input | 16 | Raw control word, sent verbatim |
| req_wdata | input | 16 | Write data word |
| busy | output | 1 | High for the whole transaction |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The completion pulse and the acceptance of the next request can fall in the same cycle. The bench raises a new request right after it sees done from a read. It then checks three things:
- the read data is correct during that pulse;
- busy returns the next cycle;
- the second frame, a write, comes out bit-exact with the full preamble.

A further scenario raises a conflicting request in the middle of a frame. It checks that the frame on the line is unchanged and that no second frame follows.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_PREAMBLE = 3'd1,
        ST_HEADER   = 3'd2,
        ST_TURN     = 3'd3,
        ST_DATA     = 3'd4
    } mdio_state_t;

    // Width of a counter able to hold values 0..n-1 (at least 1 bit)
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_now,
    output logic fall_now
);
    localparam int DIV_W = mdio_pkg::cnt_width(HALF_DIV);

    logic tick;
    logic mdc_q;

    generate
        if (HALF_DIV == 1) begin : g_nodiv
            assign tick = run;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mdc_q <= 1'b0;
                end else if (!run) begin
                    mdc_q <= 1'b0;
                end else begin
                    mdc_q <= ~mdc_q;
                end
            end
        end else begin : g_div
            logic [DIV_W-1:0] div_cnt;
            assign tick = run && (div_cnt == DIV_W'(HALF_DIV - 1));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_cnt <= '0;
                    mdc_q   <= 1'b0;
                end else if (!run) begin
                    div_cnt <= '0;
                    mdc_q   <= 1'b0;
                end else if (tick) begin
                    div_cnt <= '0;
                    mdc_q   <= ~mdc_q;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    endgenerate

    // Strobes are high in the cycle before the edge that moves mdc
    assign rise_now = tick && !mdc_q;
    assign fall_now = tick &&  mdc_q;
    assign mdc      = mdc_q;

endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
    parameter int CTRL_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              bit_now,
    output logic              bit_next
);
    localparam int W = CTRL_W + DATA_W;

    logic [W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= {ctrl_in, data_in};
        end else if (shift) begin
            sh <= {sh[W-2:0], 1'b0};
        end
    end

    assign bit_now  = sh[W-1];
    assign bit_next = sh[W-2];

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic              line_in,
    output logic [DATA_W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clear) begin
            word <= '0;
        end else if (sample) begin
            word <= {word[DATA_W-2:0], line_in};
        end
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int HALF_DIV = 2,
    parameter int PRE_LEN  = 32,
    parameter int CTRL_W   = 16,
    parameter int TA_W     = 2,
    parameter int DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [CTRL_W-1:0] req_ctrl,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    import mdio_pkg::*;

    localparam int HDR_LEN = CTRL_W - TA_W;
    localparam int MAX_PH  = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
    localparam int CNT_W   = cnt_width(MAX_PH);

    mdio_state_t      state, state_nxt;
    logic [CNT_W-1:0] bit_cnt;
    logic             is_write;
    logic             phase_last;
    logic             accept;
    logic             rise_now, fall_now;
    logic             tx_now, tx_next, tx_shift;
    logic             rx_sample;

    assign busy   = (state != ST_IDLE);
    assign accept = (state == ST_IDLE) && req_valid;

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    assign tx_shift = fall_now &&
                      (state == ST_HEADER || state == ST_TURN || state == ST_DATA);

    mdio_tx_shift #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .shift    (tx_shift),
        .ctrl_in  (req_ctrl),
        .data_in  (req_wdata),
        .bit_now  (tx_now),
        .bit_next (tx_next)
    );

    assign rx_sample = rise_now && (state == ST_DATA) && !is_write;

    mdio_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .sample  (rx_sample),
        .line_in (mdio_i),
        .word    (rd_data)
    );

    // Last bit of the current phase
    always_comb begin
        phase_last = 1'b0;
        unique case (state)
            ST_IDLE:     phase_last = 1'b0;
            ST_PREAMBLE: phase_last = (bit_cnt == CNT_W'(PRE_LEN - 1));
            ST_HEADER:   phase_last = (bit_cnt == CNT_W'(HDR_LEN - 1));
            ST_TURN:     phase_last = (bit_cnt == CNT_W'(TA_W - 1));
            ST_DATA:     phase_last = (bit_cnt == CNT_W'(DATA_W - 1));
            default:     phase_last = 1'b0;
        endcase
    end

    // Next-state logic: phases advance on the falling-edge strobe
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:     if (req_valid)              state_nxt = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_now && phase_last) state_nxt = ST_HEADER;
            ST_HEADER:   if (fall_now && phase_last) state_nxt = ST_TURN;
            ST_TURN:     if (fall_now && phase_last) state_nxt = ST_DATA;
            ST_DATA:     if (fall_now && phase_last) state_nxt = ST_IDLE;
            default:                                 state_nxt = ST_IDLE;
        endcase
    end

    // State register with bit counter and direction flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            is_write <= 1'b0;
        end else begin
            state <= state_nxt;
            if (accept) begin
                bit_cnt  <= '0;
                is_write <= req_write;
            end else if (fall_now) begin
                bit_cnt <= phase_last ? '0 : bit_cnt + 1'b1;
            end
        end
    end

    // Output register: line value, enable and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= (state == ST_DATA) && fall_now && phase_last;
            if (accept) begin
                mdio_o  <= 1'b1;
                mdio_oe <= 1'b1;
            end else if (fall_now) begin
                unique case (state)
                    ST_IDLE: begin
                        mdio_o <= 1'b1;
                    end
                    ST_PREAMBLE: begin
                        mdio_o <= phase_last ? tx_now : 1'b1;
                    end
                    ST_HEADER: begin
                        mdio_o <= tx_next;
                        if (phase_last && !is_write) begin
                            mdio_oe <= 1'b0;
                        end
                    end
                    ST_TURN: begin
                        mdio_o <= tx_next;
                    end
                    ST_DATA: begin
                        if (phase_last) begin
                            mdio_o  <= 1'b1;
                            mdio_oe <= 1'b0;
                        end else begin
                            mdio_o <= tx_next;
                        end
                    end
                    default: begin
                        mdio_o <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/mdio_master_checker.sv
module mdio_master_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe
);
    // R7: management clock rests low outside a transaction
    assert_idle_clock_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R1 / R6: line released whenever no transaction runs
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    // R2: an idle request starts a transaction
    assert_accept_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R9: completion is a single-cycle pulse
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: completion marks the end of a busy period
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R8: driven data moves only with a falling management clock
    assert_change_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

endmodule

bind mdio_master mdio_master_checker u_mdio_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;

    localparam int HALF = 2;
    localparam int FRAME_CYC = 128 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_ctrl = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i;
    logic        phy_en = 1'b0;
    logic        phy_val = 1'b1;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    // 50 MHz system clock
    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Shared line: master, PHY model, or pull-up
    assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_val : 1'b1);

    mdio_master #(.HALF_DIV(HALF)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ctrl  (req_ctrl),
        .req_wdata (req_wdata),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one frame; checks line bits, timing, completion and read data.
    // chain=1 returns in the done cycle so the caller can start another.
    task automatic do_frame(input string name, input logic wr, input logic [15:0] ctrl,
                            input logic [15:0] wdata, input logic [15:0] phy,
                            input bit inject, input bit chain);
        int acc;
        int bad_pre, bad_hdr, bad_ta, bad_dat, bad_oe;
        bit stable_ok;
        logic expb, expoe, v;
        int guard;
        bad_pre = -1; bad_hdr = -1; bad_ta = -1; bad_dat = -1; bad_oe = -1;
        stable_ok = 1'b1;
        req_valid = 1'b1; req_write = wr; req_ctrl = ctrl; req_wdata = wdata;
        @(posedge clk); #1;
        req_valid = 1'b0; req_ctrl = ~ctrl; req_wdata = ~wdata;
        acc = cyc;
        chk(busy == 1'b1, "R2", {name, " busy after accept"}, busy, 1);
        for (int k = 0; k < 64; k++) begin
            @(posedge mdc); #1;
            if (k < 32)       expb = 1'b1;
            else if (k < 48)  expb = ctrl[47-k];
            else              expb = wr ? wdata[63-k] : phy[63-k];
            if (!wr && (k == 46 || k == 47)) expb = 1'b1;
            expoe = (k < 46) ? 1'b1 : wr;
            if (mdio_i !== expb) begin
                if (k < 32 && bad_pre < 0) bad_pre = k;
                else if (k >= 32 && k < 46 && bad_hdr < 0) bad_hdr = k;
                else if (k >= 46 && k < 48 && bad_ta < 0) bad_ta = k;
                else if (k >= 48 && bad_dat < 0) bad_dat = k;
            end
            if (mdio_oe !== expoe && bad_oe < 0) bad_oe = k;
            v = mdio_o;
            // stay until the falling edge, checking the driven value holds
            forever begin
                @(negedge clk);
                if (!mdc) break;
                if (mdio_o !== v) stable_ok = 1'b0;
            end
            if (k < 63) begin
                if (!wr && k + 1 >= 48) begin
                    phy_en = 1'b1; phy_val = phy[62-k];
                end else begin
                    phy_en = 1'b0;
                end
            end
            if (inject && k == 20) begin
                req_valid = 1'b1; req_write = ~wr; req_ctrl = ~ctrl;
                @(posedge clk); #1;
                req_valid = 1'b0;
            end
        end
        phy_en = 1'b0;
        chk(bad_pre < 0, "R3", {name, " preamble bit index"}, bad_pre, -1);
        chk(bad_hdr < 0, "R4", {name, " header bit index"}, bad_hdr, -1);
        if (wr) begin
            chk(bad_ta < 0, "R5", {name, " turnaround bit index"}, bad_ta, -1);
            chk(bad_dat < 0, "R5", {name, " write data bit index"}, bad_dat, -1);
            chk(bad_oe < 0, "R5", {name, " enable bit index"}, bad_oe, -1);
        end else begin
            chk(bad_oe < 0, "R6", {name, " release bit index"}, bad_oe, -1);
        end
        chk(stable_ok, "R8", {name, " data stable while mdc high"}, stable_ok, 1);
        guard = 0;
        while (!done && guard < 50) begin
            @(posedge clk); #1; guard++;
        end
        chk(done == 1'b1, "R9", {name, " done seen"}, done, 1);
        chk(cyc - acc == FRAME_CYC, "R7", {name, " frame length"}, cyc - acc, FRAME_CYC);
        chk(busy == 1'b0 && mdc == 1'b0, "R7", {name, " idle at done"}, {busy, mdc}, 0);
        if (!wr) chk(rd_data == phy, "R6", {name, " read data"}, rd_data, phy);
        else     chk(rd_data == 16'h0, "R9", {name, " read data cleared"}, rd_data, 0);
        if (!chain) begin
            @(posedge clk); #1;
            chk(done == 1'b0, "R9", {name, " done one cycle"}, done, 0);
            repeat (6) @(posedge clk);
            #1;
            chk(busy == 1'b0, "R2", {name, " no extra frame"}, busy, 0);
            if (!wr) chk(rd_data == phy, "R9", {name, " read data held"}, rd_data, phy);
        end
    endtask

    task automatic test_reset();
        chk(busy == 0 && done == 0 && mdc == 0 && mdio_oe == 0, "R1",
            "control outputs after reset", {busy, done, mdc, mdio_oe}, 0);
        chk(rd_data == 16'h0, "R1", "rd_data after reset", rd_data, 0);
    endtask

    task automatic test_std_write();
        do_frame("std write", 1'b1, 16'b01_01_00011_01001_10, 16'hA5C3, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic test_std_read();
        do_frame("std read", 1'b0, 16'b01_10_10101_00110_00, 16'h0, 16'h3C96, 1'b0, 1'b0);
    endtask

    task automatic test_vendor_opcode();
        // opcode 00 and arbitrary turnaround bits pass through (R4, R5)
        do_frame("opcode 00 write", 1'b1, 16'b01_00_11111_10000_01, 16'h8001, 16'h0, 1'b0, 1'b0);
    endtask

    task automatic test_read_patterns();
        do_frame("read ones", 1'b0, 16'h6BFC, 16'h0, 16'hFFFF, 1'b0, 1'b0);
        do_frame("read zeros", 1'b0, 16'h6000, 16'h0, 16'h0000, 1'b0, 1'b0);
    endtask

    task automatic test_ignored_request();
        do_frame("busy request ignored", 1'b1, 16'h5A5A, 16'h1234, 16'h0, 1'b1, 1'b0);
    endtask

    task automatic test_back_to_back();
        do_frame("chain read", 1'b0, 16'h6842, 16'h0, 16'hBEEF, 1'b0, 1'b1);
        // R10: next request raised in the done cycle
        do_frame("chain write R10", 1'b1, 16'h5096, 16'hC0DE, 16'h0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 test_reset();
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1 test_reset();
        test_std_write();
        test_std_read();
        test_vendor_opcode();
        test_read_patterns();
        test_ignored_request();
        test_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule